// File: doc/BRIEF.md
# Thermal Clock-Modulation Throttle Controller

This block drives a core clock-enable. When the die gets too hot, it gates that enable in a repeating pattern to lower average switching activity. Two sources can request throttling. The first is automatic: a digital temperature code is compared against a trip level, with a hysteresis band on the way down, and the duty is fixed at 50%. The second is on-demand: a software-written control register forces modulation at a programmed duty, whatever the temperature.

Time is divided into frames of eight slots. Each slot lasts a parameterized number of reference clocks. A duty code N keeps the clock enabled for the first N slots of a frame and gates it for the remaining 8-N slots. The active pattern is reloaded only at a frame boundary, so a pulse is never cut short. When both sources ask at once, the automatic source wins. The status output reports whether the current frame is modulating.

Top module: `therm_throttle`

## Requirements
- R1: After reset, clkEn is 1, throttleActive is 0 and ctrlRdata reads 0.
- R2: An internal hot flag sets on any clock where tempCode > tripLevel (strict). While autoEn=1 and hot, frames use duty code 4: 4 slots enabled, then 4 slots gated.
- R3: Once set, the hot flag clears only when tempCode + hystBand < tripLevel. Temperatures between that level and tripLevel keep it set.
- R4: Writing ctrlWdata with bit 4 = 1 enables on-demand mode, and bits 3:1 give duty code N (1..7). Frames then enable the clock for slots 0..N-1 and gate slots N..7, whatever the temperature.
- R5: On-demand mode with duty code 0 causes no throttling.
- R6: When autoEn=1 and the hot flag is set, duty 4 is used even if on-demand is enabled with another code.
- R7: With autoEn=0, temperature has no effect on clkEn or throttleActive.
- R8: A frame is 8 slots of SLOT_CYCLES clocks each and runs freely from reset. A change of mode or duty takes effect only at the first clock of the next frame.
- R9: throttleActive is 1 exactly during frames that modulate, and clkEn is 1 whenever throttleActive is 0.
- R10: ctrlRdata returns bits 4:1 as last written; bits 7:5 and bit 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tempCode | input | TEMP_W | Digital temperature reading |
| tripLevel | input | TEMP_W | Over-temperature threshold |
| hystBand | input | TEMP_W | Hysteresis width below the threshold |
| autoEn | input | 1 | Enables automatic temperature throttling |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 8 | Control register write data |
| ctrlRdata | output | 8 | Control register readback |
| clkEn | output | 1 | Core clock enable |
| throttleActive | output | 1 | High while the current frame modulates |

## Verification
The bench builds the block with SLOT_CYCLES=3 and TEMP_W=8, so a full frame is 24 clocks. Many frames then fit into a short run, and every duty code, mid-frame request changes and frame-boundary reloads can be reached. The 8-bit temperature code lets the bench place readings exactly on the trip level, exactly on the lower hysteresis edge, and one count on either side of each.

// File: rtl/therm_throttle_pkg.sv
package therm_throttle_pkg;
  localparam int FRAME_SLOTS = 8;
  localparam int DUTY_W      = $clog2(FRAME_SLOTS);
  localparam int REG_W       = 8;
  localparam int OD_EN_BIT   = 4;
  localparam int DUTY_LSB    = 1;
  localparam logic [DUTY_W-1:0] AUTO_DUTY = DUTY_W'(FRAME_SLOTS / 2);

  typedef struct packed {
    logic              modReq;
    logic [DUTY_W-1:0] duty;
  } throttleCmd_t;
endpackage

// File: rtl/therm_throttle_ctrl.sv
module therm_throttle_ctrl
  import therm_throttle_pkg::*;
#(
  parameter int TEMP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] tempCode,
  input  logic [TEMP_W-1:0] tripLevel,
  input  logic [TEMP_W-1:0] hystBand,
  input  logic              autoEn,
  input  logic              ctrlWe,
  input  logic [REG_W-1:0]  ctrlWdata,
  output logic [REG_W-1:0]  ctrlRdata,
  output throttleCmd_t      cmd
);
  logic              hot;
  logic              odEn;
  logic [DUTY_W-1:0] odDuty;
  logic [TEMP_W:0]   lowSum;
  logic              overTrip;
  logic              belowBand;

  assign lowSum    = {1'b0, tempCode} + {1'b0, hystBand};
  assign overTrip  = tempCode > tripLevel;
  assign belowBand = lowSum < {1'b0, tripLevel};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hot <= 1'b0;
    end else if (overTrip) begin
      hot <= 1'b1;
    end else if (belowBand) begin
      hot <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      odEn   <= 1'b0;
      odDuty <= '0;
    end else if (ctrlWe) begin
      odEn   <= ctrlWdata[OD_EN_BIT];
      odDuty <= ctrlWdata[DUTY_LSB +: DUTY_W];
    end
  end

  always_comb begin
    ctrlRdata                       = '0;
    ctrlRdata[OD_EN_BIT]            = odEn;
    ctrlRdata[DUTY_LSB +: DUTY_W]   = odDuty;
  end

  always_comb begin
    cmd = '0;
    if (autoEn && hot) begin
      cmd.modReq = 1'b1;
      cmd.duty   = AUTO_DUTY;
    end else if (odEn && (odDuty != '0)) begin
      cmd.modReq = 1'b1;
      cmd.duty   = odDuty;
    end
  end

  AST_HOT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    overTrip |=> hot); // R2

  AST_HOT_HOLDS_IN_BAND: assert property (@(posedge clk) disable iff (!rstN)
    (hot && !belowBand) |=> hot); // R3

  AST_CLEAR_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hot) |-> $past(belowBand)); // R3
endmodule

// File: rtl/therm_throttle_dp.sv
module therm_throttle_dp
  import therm_throttle_pkg::*;
#(
  parameter int SLOT_CYCLES = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  throttleCmd_t cmd,
  output logic         clkEn,
  output logic         throttleActive
);
  localparam int SLOT_W = $clog2(FRAME_SLOTS);
  localparam int CNT_W  = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;

  logic              slotEnd;
  logic              frameEnd;
  logic [SLOT_W-1:0] slotIdx;
  logic              actMod;
  logic [DUTY_W-1:0] actDuty;

  generate
    if (SLOT_CYCLES > 1) begin : gSlotCnt
      logic [CNT_W-1:0] slotCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          slotCnt <= '0;
        end else if (slotEnd) begin
          slotCnt <= '0;
        end else begin
          slotCnt <= slotCnt + 1'b1;
        end
      end
      assign slotEnd = (slotCnt == CNT_W'(SLOT_CYCLES - 1));
    end else begin : gSlotOne
      assign slotEnd = 1'b1;
    end
  endgenerate

  assign frameEnd = slotEnd && (slotIdx == SLOT_W'(FRAME_SLOTS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotIdx <= '0;
    end else if (slotEnd) begin
      slotIdx <= slotIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actMod  <= 1'b0;
      actDuty <= '0;
    end else if (frameEnd) begin
      actMod  <= cmd.modReq;
      actDuty <= cmd.duty;
    end
  end

  assign throttleActive = actMod;
  assign clkEn          = !actMod || (slotIdx < actDuty);

  AST_IDLE_CLOCK_ON: assert property (@(posedge clk) disable iff (!rstN)
    !throttleActive |-> clkEn); // R9

  AST_NO_MIDFRAME_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(frameEnd) |-> ($stable(actMod) && $stable(actDuty))); // R8

  AST_FIRST_SLOT_ON: assert property (@(posedge clk) disable iff (!rstN)
    (throttleActive && slotIdx == '0) |-> clkEn); // R4

  AST_LAST_SLOT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (throttleActive && slotIdx == SLOT_W'(FRAME_SLOTS - 1)) |-> !clkEn); // R4
endmodule

// File: rtl/therm_throttle.sv
module therm_throttle
  import therm_throttle_pkg::*;
#(
  parameter int TEMP_W      = 8,
  parameter int SLOT_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] tempCode,
  input  logic [TEMP_W-1:0] tripLevel,
  input  logic [TEMP_W-1:0] hystBand,
  input  logic              autoEn,
  input  logic              ctrlWe,
  input  logic [7:0]        ctrlWdata,
  output logic [7:0]        ctrlRdata,
  output logic              clkEn,
  output logic              throttleActive
);
  throttleCmd_t cmd;

  therm_throttle_ctrl #(.TEMP_W(TEMP_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .tempCode(tempCode), .tripLevel(tripLevel),
    .hystBand(hystBand), .autoEn(autoEn), .ctrlWe(ctrlWe),
    .ctrlWdata(ctrlWdata), .ctrlRdata(ctrlRdata), .cmd(cmd)
  );

  therm_throttle_dp #(.SLOT_CYCLES(SLOT_CYCLES)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .clkEn(clkEn),
    .throttleActive(throttleActive)
  );
endmodule

// File: tb/therm_throttle_tb_top.sv
module therm_throttle_tb_top;
  localparam int TW   = 8;
  localparam int SLOT = 3;
  localparam int FRAME = 8 * SLOT;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [TW-1:0] tempCode = '0;
  logic [TW-1:0] tripLevel = 8'd100;
  logic [TW-1:0] hystBand = 8'd10;
  logic          autoEn = 1'b0;
  logic          ctrlWe = 1'b0;
  logic [7:0]    ctrlWdata = '0;
  logic [7:0]    ctrlRdata;
  logic          clkEn;
  logic          throttleActive;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int cycles = 0;

  // behavioural reference state
  int mPos = 0;
  int mHot = 0;
  int mOdEn = 0;
  int mOdDuty = 0;
  int mMod = 0;
  int mDuty = 0;
  int mSrc = 0; // 0 none, 1 auto, 2 on-demand, 3 auto overriding on-demand

  always #10 clk = ~clk;

  therm_throttle #(.TEMP_W(TW), .SLOT_CYCLES(SLOT)) dut_i (
    .clk(clk), .rstN(rstN), .tempCode(tempCode), .tripLevel(tripLevel),
    .hystBand(hystBand), .autoEn(autoEn), .ctrlWe(ctrlWe),
    .ctrlWdata(ctrlWdata), .ctrlRdata(ctrlRdata), .clkEn(clkEn),
    .throttleActive(throttleActive)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cycles, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mPos = 0; mHot = 0; mOdEn = 0; mOdDuty = 0; mMod = 0; mDuty = 0; mSrc = 0;
    end else begin
      int rMod, rDuty, rSrc;
      rMod = 0; rDuty = 0; rSrc = 0;
      if (autoEn && mHot != 0) begin
        rMod = 1; rDuty = 4; rSrc = (mOdEn != 0 && mOdDuty != 0) ? 3 : 1;
      end else if (mOdEn != 0 && mOdDuty != 0) begin
        rMod = 1; rDuty = mOdDuty; rSrc = 2;
      end
      if (mPos == FRAME - 1) begin
        mMod = rMod; mDuty = rDuty; mSrc = rSrc;
      end
      mPos = (mPos + 1) % FRAME;
      if (int'(tempCode) > int'(tripLevel)) mHot = 1;
      else if (int'(tempCode) + int'(hystBand) < int'(tripLevel)) mHot = 0;
      if (ctrlWe) begin
        mOdEn = ctrlWdata[4];
        mOdDuty = int'(ctrlWdata[3:1]);
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      int expEn;
      string tag;
      expEn = (mMod == 0 || (mPos / SLOT) < mDuty) ? 1 : 0;
      case (mSrc)
        1: tag = "R2 auto duty";
        2: tag = "R4 on-demand duty";
        3: tag = "R6 auto priority";
        default: tag = autoEn ? "R8 frame idle" : "R7 auto disabled";
      endcase
      check(tag, int'(clkEn), expEn);
      check("R9 throttleActive", int'(throttleActive), mMod);
      check("R10 readback", int'(ctrlRdata), (mOdEn << 4) | (mOdDuty << 1));
    end
  end

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeCtrl(input logic [7:0] v);
    @(negedge clk);
    ctrlWdata = v;
    ctrlWe = 1'b1;
    @(negedge clk);
    ctrlWe = 1'b0;
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    while (cycles < 100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    waitCycles(3);
    // R1: reset state
    check("R1 clkEn", int'(clkEn), 1);
    check("R1 throttleActive", int'(throttleActive), 0);
    check("R1 readback", int'(ctrlRdata), 0);
    rstN = 1'b1;
    autoEn = 1'b1;
    tempCode = 8'd50;
    waitCycles(30);
    tempCode = 8'd100;              // equal to trip: no set (R2)
    waitCycles(2 * FRAME);
    check("R2 equal trip no throttle", int'(throttleActive), 0);
    tempCode = 8'd101;              // R2 over trip
    waitCycles(3 * FRAME);
    tempCode = 8'd95;               // R3 inside band
    waitCycles(2 * FRAME);
    tempCode = 8'd90;               // R3 lower edge, still hot
    waitCycles(2 * FRAME);
    check("R3 hold at band edge", int'(throttleActive), 1);
    tempCode = 8'd89;               // R3 clears
    waitCycles(2 * FRAME);
    check("R3 cleared below band", int'(throttleActive), 0);
    // R4 and R5: every duty code, bit 0 and upper bits written to test R10
    for (int n = 0; n < 8; n++) begin
      writeCtrl(8'hE1 | 8'h10 | 8'(n << 1));
      waitCycles(2 * FRAME + 5);
      if (n == 0) check("R5 code zero idle", int'(throttleActive), 0);
    end
    writeCtrl(8'h1E);               // duty 7
    waitCycles(FRAME);
    tempCode = 8'd130;              // R6 auto overrides
    waitCycles(3 * FRAME);
    autoEn = 1'b0;                  // R7 hot but auto disabled, od duty 7 continues
    waitCycles(2 * FRAME);
    writeCtrl(8'h00);
    waitCycles(2 * FRAME);
    check("R7 hot ignored when auto off", int'(throttleActive), 0);
    // R8 mid-frame changes
    writeCtrl(8'h14);               // duty 2
    waitCycles(7);
    writeCtrl(8'h1A);               // duty 5 mid-frame
    waitCycles(11);
    writeCtrl(8'h00);
    waitCycles(2 * FRAME);
    autoEn = 1'b1;
    tempCode = 8'd10;
    waitCycles(2 * FRAME);
    finishRun();
  end
endmodule